// File: doc/BRIEF.md
# Cache line maintenance sequencer

This engine takes one range maintenance request for a virtually indexed, physically tagged cache and expands it into a stream of per-line register writes. A request carries a physical address, a virtual address, a byte count, an operation code and an addressing-mode bit. The engine rounds the range out to whole cache lines and counts the lines. It then walks the range and emits one command write per line. A physical-tag write is added wherever the chosen addressing mode needs one.

There are two addressing modes. In packed mode the virtual index bits travel in the line-offset bits of the physical address, so each line needs only one command write. In tag mode a separate physical-tag register receives the physical address and the command register receives the virtual address. When a tag-mode request covers exactly one page, the tag is written once before the walk. Each outgoing write is a one-cycle strobe with a select code and a 32-bit value. A done pulse marks the end of the request.

States: `ST_IDLE` (ready, accepts a request), `ST_TAG_ONCE` (single page-wide tag write), `ST_LINE_TAG` (per-line tag write), `ST_LINE_CMD` (per-line command write), `ST_DONE` (done pulse). Transitions: IDLE→DONE on a zero-size request; IDLE→TAG_ONCE on a tag-mode full page; IDLE→LINE_TAG on other tag-mode requests; IDLE→LINE_CMD in packed mode; TAG_ONCE→LINE_CMD; LINE_TAG→LINE_CMD; LINE_CMD→LINE_TAG (tag mode, partial range, lines left); LINE_CMD→LINE_CMD (packed mode or full-page tag mode, lines left); LINE_CMD→DONE after the last line; DONE→IDLE.

Top module: `cmo_line_sequencer`

## Requirements
- R1: Select codes: 1 = instruction line invalidate, 2 = data line invalidate, 3 = data line flush, 4 = instruction physical tag, 5 = data physical tag. Op 4 uses codes 1 and 4. Any other op uses code 5 for its tags, code 2 for its commands when op bit 0 is 1, and code 3 when op bit 0 is 0.
- R2: A request whose size is not exactly one page is aligned first: the physical start offset within the line is added to the size, and both addresses are rounded down to a line boundary.
- R3: The number of command writes equals the adjusted size divided by the line length, rounded up.
- R4: In packed mode, virtual address bits [PAGE_SHIFT+4:PAGE_SHIFT] (bits [17:13] at the default page size) are ORed into bits [4:0] of every command value.
- R5: In packed mode, there is exactly one command write per line and no tag writes. The physical address in successive commands rises by one line length.
- R6: In tag mode with a partial-page request, each line gets a tag write of the physical address, followed in the next cycle by a command write of the virtual address. Both addresses rise by one line length per line.
- R7: In tag mode with a request of exactly one page, a single tag write of the unaligned physical address comes first. Every following write is a command carrying the virtual address, which rises by one line per line.
- R8: A zero-size request produces no writes, and done is raised in the cycle after acceptance.
- R9: req_ready is high only while idle. The writes of a request occupy consecutive cycles starting the cycle after acceptance. done is high for one cycle, directly after the last write, and ready returns the cycle after that.
- R10: A packed-mode request of exactly one page is not re-aligned and issues page/line commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle, request accepted when valid |
| req_paddr | input | 32 | Physical start address |
| req_vaddr | input | 32 | Virtual start address |
| req_size | input | 32 | Byte count |
| req_op | input | 3 | Operation: 1 inv, 2 flush, 3 flush+inv, 4 instruction inv |
| req_tagmode | input | 1 | 1 = separate tag register, 0 = packed index bits |
| wr_strobe | output | 1 | One-cycle register write |
| wr_sel | output | 3 | Target register select code (0 when idle) |
| wr_data | output | 32 | Value written |
| done | output | 1 | One-cycle completion pulse |

## Verification
A wrong line counter shows as a missing or extra command write, and done then arrives on the wrong cycle, so the error is visible within one line of the range end. A wrong address register or alignment decision shows in the first write's data, one cycle after acceptance. A wrong mode or op latch shows as a wrong select code on that same write. A state sequence that is out of step shows as tag and command writes that are not paired, or as a second tag write in a full-page request. The bench compares every write and the done cycle against a model built from the requirements.

// File: rtl/cmo_seq_pkg.sv
package cmo_seq_pkg;

    typedef enum logic [2:0] {
        SEL_NONE     = 3'd0,
        SEL_IC_INV   = 3'd1,
        SEL_DC_INV   = 3'd2,
        SEL_DC_FLUSH = 3'd3,
        SEL_IC_TAG   = 3'd4,
        SEL_DC_TAG   = 3'd5
    } wsel_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TAG_ONCE,
        ST_LINE_TAG,
        ST_LINE_CMD,
        ST_DONE
    } state_e;

    localparam logic [2:0] OP_IC_INV = 3'd4;
    localparam int         PACK_W    = 5;

endpackage

// File: rtl/cmo_range_calc.sv
module cmo_range_calc
    import cmo_seq_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 32,
    parameter int LINE_BYTES = 32,
    parameter int PAGE_BYTES = 8192,
    parameter int CNT_W      = LEN_W + 2 - $clog2(LINE_BYTES)
) (
    input  logic [ADDR_W-1:0] paddr,
    input  logic [ADDR_W-1:0] vaddr,
    input  logic [LEN_W-1:0]  size,
    input  logic [2:0]        op,
    output logic [ADDR_W-1:0] start_p,
    output logic [ADDR_W-1:0] start_v,
    output logic [ADDR_W-1:0] pack_bits,
    output logic [CNT_W-1:0]  nlines,
    output logic              full_page,
    output logic              zero_len,
    output wsel_e             cmd_sel,
    output wsel_e             tag_sel
);
    localparam int LINE_SH = $clog2(LINE_BYTES);
    localparam int PAGE_SH = $clog2(PAGE_BYTES);
    localparam int SUM_W   = LEN_W + 2;
    localparam logic [ADDR_W-1:0] LINE_MASK = ~ADDR_W'(LINE_BYTES - 1);

    logic [SUM_W-1:0] adj_size;
    logic [SUM_W-1:0] rounded;

    always_comb begin
        full_page = (size == LEN_W'(PAGE_BYTES));
        zero_len  = (size == '0);

        // Partial ranges are widened to whole lines; a full page is taken as-is.
        if (full_page) begin
            adj_size = SUM_W'(size);
            start_p  = paddr;
            start_v  = vaddr;
        end else begin
            adj_size = SUM_W'(size) + SUM_W'(paddr[LINE_SH-1:0]);
            start_p  = paddr & LINE_MASK;
            start_v  = vaddr & LINE_MASK;
        end

        rounded   = adj_size + SUM_W'(LINE_BYTES - 1);
        nlines    = rounded[SUM_W-1:LINE_SH];
        pack_bits = ADDR_W'(vaddr[PAGE_SH+PACK_W-1:PAGE_SH]);

        if (op == OP_IC_INV) begin
            cmd_sel = SEL_IC_INV;
            tag_sel = SEL_IC_TAG;
        end else begin
            cmd_sel = op[0] ? SEL_DC_INV : SEL_DC_FLUSH;
            tag_sel = SEL_DC_TAG;
        end
    end

    // R3: a non-empty range always spans at least one line
    always_comb begin
        if (!zero_len) begin
            a_r3_nonzero_lines: assert (nlines != '0);
        end
    end

endmodule

// File: rtl/cmo_seq_fsm.sv
module cmo_seq_fsm
    import cmo_seq_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 32,
    parameter int CNT_W      = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_tagmode,
    input  logic [ADDR_W-1:0] start_p,
    input  logic [ADDR_W-1:0] start_v,
    input  logic [ADDR_W-1:0] pack_bits,
    input  logic [CNT_W-1:0]  nlines,
    input  logic              full_page,
    input  logic              zero_len,
    input  wsel_e             cmd_sel,
    input  wsel_e             tag_sel,
    output logic              wr_strobe,
    output logic [2:0]        wr_sel,
    output logic [ADDR_W-1:0] wr_data,
    output logic              done
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(LINE_BYTES);

    state_e            state_q, state_d;
    logic [ADDR_W-1:0] p_q, v_q, pack_q;
    logic [CNT_W-1:0]  left_q;
    logic              tagm_q, full_q;
    wsel_e             cmd_q, tag_q;
    logic              accept;
    logic              last_line;

    assign accept    = req_valid && (state_q == ST_IDLE);
    assign last_line = (left_q == CNT_W'(1));

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    if (zero_len)                     state_d = ST_DONE;
                    else if (req_tagmode && full_page) state_d = ST_TAG_ONCE;
                    else if (req_tagmode)             state_d = ST_LINE_TAG;
                    else                              state_d = ST_LINE_CMD;
                end
            end
            ST_TAG_ONCE: state_d = ST_LINE_CMD;
            ST_LINE_TAG: state_d = ST_LINE_CMD;
            ST_LINE_CMD: begin
                if (last_line)                state_d = ST_DONE;
                else if (tagm_q && !full_q)   state_d = ST_LINE_TAG;
                else                          state_d = ST_LINE_CMD;
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Request context and walking addresses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_q    <= '0;
            v_q    <= '0;
            pack_q <= '0;
            left_q <= '0;
            tagm_q <= 1'b0;
            full_q <= 1'b0;
            cmd_q  <= SEL_NONE;
            tag_q  <= SEL_NONE;
        end else if (accept) begin
            p_q    <= start_p;
            v_q    <= start_v;
            pack_q <= pack_bits;
            left_q <= nlines;
            tagm_q <= req_tagmode;
            full_q <= full_page;
            cmd_q  <= cmd_sel;
            tag_q  <= tag_sel;
        end else if (state_q == ST_LINE_TAG) begin
            p_q <= p_q + STEP;
        end else if (state_q == ST_LINE_CMD) begin
            v_q    <= v_q + STEP;
            left_q <= left_q - CNT_W'(1);
            if (!tagm_q) p_q <= p_q + STEP;
        end
    end

    // Outputs
    always_comb begin
        req_ready = 1'b0;
        wr_strobe = 1'b0;
        wr_sel    = SEL_NONE;
        wr_data   = '0;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE: req_ready = 1'b1;
            ST_TAG_ONCE, ST_LINE_TAG: begin
                wr_strobe = 1'b1;
                wr_sel    = tag_q;
                wr_data   = p_q;
            end
            ST_LINE_CMD: begin
                wr_strobe = 1'b1;
                wr_sel    = cmd_q;
                wr_data   = tagm_q ? v_q : (p_q | pack_q);
            end
            ST_DONE: done = 1'b1;
            default: ;
        endcase
    end

    // R9: no write while the engine would take a new request
    a_r9_no_write_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe |-> !req_ready);

    // R9: done is a single pulse followed by idle
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && req_ready));

    // R6: every tag write is followed at once by a command write
    a_r6_tag_then_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_strobe && (wr_sel == SEL_IC_TAG || wr_sel == SEL_DC_TAG))
        |=> (wr_strobe && wr_sel != SEL_IC_TAG && wr_sel != SEL_DC_TAG));

    // R7: a full-page tag-mode walk never returns to per-line tags
    a_r7_single_tag: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LINE_CMD && tagm_q && full_q) |=> (state_q != ST_LINE_TAG));

    // R5: back-to-back packed commands advance by one line
    a_r5_packed_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LINE_CMD && !tagm_q && !last_line)
        |=> (wr_data == $past(wr_data) + STEP));

    // R8: a zero-size request finishes without writes
    a_r8_zero_done: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && zero_len) |=> (done && !wr_strobe));

    // R3: the line counter drops by one per command
    a_r3_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LINE_CMD && !last_line) |=> (left_q == $past(left_q) - CNT_W'(1)));

endmodule

// File: rtl/cmo_line_sequencer.sv
module cmo_line_sequencer
    import cmo_seq_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 32,
    parameter int LINE_BYTES = 32,
    parameter int PAGE_BYTES = 8192
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_paddr,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic [LEN_W-1:0]  req_size,
    input  logic [2:0]        req_op,
    input  logic              req_tagmode,
    output logic              wr_strobe,
    output logic [2:0]        wr_sel,
    output logic [ADDR_W-1:0] wr_data,
    output logic              done
);
    localparam int LINE_SH = $clog2(LINE_BYTES);
    localparam int CNT_W   = LEN_W + 2 - LINE_SH;

    logic [ADDR_W-1:0] start_p, start_v, pack_bits;
    logic [CNT_W-1:0]  nlines;
    logic              full_page, zero_len;
    wsel_e             cmd_sel, tag_sel;

    cmo_range_calc #(
        .ADDR_W     (ADDR_W),
        .LEN_W      (LEN_W),
        .LINE_BYTES (LINE_BYTES),
        .PAGE_BYTES (PAGE_BYTES),
        .CNT_W      (CNT_W)
    ) u_calc (
        .paddr     (req_paddr),
        .vaddr     (req_vaddr),
        .size      (req_size),
        .op        (req_op),
        .start_p   (start_p),
        .start_v   (start_v),
        .pack_bits (pack_bits),
        .nlines    (nlines),
        .full_page (full_page),
        .zero_len  (zero_len),
        .cmd_sel   (cmd_sel),
        .tag_sel   (tag_sel)
    );

    cmo_seq_fsm #(
        .ADDR_W     (ADDR_W),
        .LINE_BYTES (LINE_BYTES),
        .CNT_W      (CNT_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_tagmode (req_tagmode),
        .start_p     (start_p),
        .start_v     (start_v),
        .pack_bits   (pack_bits),
        .nlines      (nlines),
        .full_page   (full_page),
        .zero_len    (zero_len),
        .cmd_sel     (cmd_sel),
        .tag_sel     (tag_sel),
        .wr_strobe   (wr_strobe),
        .wr_sel      (wr_sel),
        .wr_data     (wr_data),
        .done        (done)
    );

endmodule

// File: tb/sim_cmo_line_sequencer.sv
module sim_cmo_line_sequencer;
    localparam int CLK_PERIOD = 10;
    localparam int LINE       = 32;
    localparam int PAGE       = 8192;
    localparam int PSH        = 13;
    localparam int MAXW       = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_paddr = '0, req_vaddr = '0, req_size = '0;
    logic [2:0]  req_op = 3'd1;
    logic        req_tagmode = 1'b0;
    logic        wr_strobe;
    logic [2:0]  wr_sel;
    logic [31:0] wr_data;
    logic        done;

    int vectors = 0;
    int errors  = 0;
    int cycles  = 0;

    logic [2:0]  exp_sel  [0:MAXW-1];
    logic [31:0] exp_data [0:MAXW-1];
    int          exp_n;
    logic [2:0]  got_sel  [0:MAXW-1];
    logic [31:0] got_data [0:MAXW-1];
    int          got_n;

    cmo_line_sequencer u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_paddr(req_paddr), .req_vaddr(req_vaddr), .req_size(req_size),
        .req_op(req_op), .req_tagmode(req_tagmode), .wr_strobe(wr_strobe),
        .wr_sel(wr_sel), .wr_data(wr_data), .done(done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cycles <= cycles + 1;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic push(input logic [2:0] s, input logic [31:0] d);
        if (exp_n < MAXW) begin
            exp_sel[exp_n]  = s;
            exp_data[exp_n] = d;
        end
        exp_n++;
    endtask

    // Expected write list built from the requirements
    task automatic build_exp(input logic [31:0] pa, input logic [31:0] va, input logic [31:0] sz,
                             input logic [2:0] op, input bit tm);
        logic [31:0] p, v, pk;
        longint unsigned adj, n;
        logic [2:0] cs, ts;
        bit full;
        exp_n = 0;
        if (sz == 0) return;
        full = (sz == PAGE);
        p = pa; v = va; adj = sz;
        if (!full) begin
            adj = adj + (pa % LINE);
            p = pa & ~32'(LINE - 1);
            v = va & ~32'(LINE - 1);
        end
        n  = (adj + LINE - 1) / LINE;
        cs = (op == 3'd4) ? 3'd1 : (op[0] ? 3'd2 : 3'd3);
        ts = (op == 3'd4) ? 3'd4 : 3'd5;
        pk = (va >> PSH) & 32'h1F;
        if (!tm) begin
            for (longint unsigned i = 0; i < n; i++) begin
                push(cs, p | pk);
                p = p + LINE;
            end
        end else begin
            if (full) push(ts, p);
            for (longint unsigned i = 0; i < n; i++) begin
                if (!full) begin
                    push(ts, p);
                    p = p + LINE;
                end
                push(cs, v);
                v = v + LINE;
            end
        end
    endtask

    task automatic run_req(input logic [31:0] pa, input logic [31:0] va, input logic [31:0] sz,
                           input logic [2:0] op, input bit tm, input string tag);
        int cyc, done_cyc;
        build_exp(pa, va, sz, op, tm);
        @(negedge clk);
        check(req_ready === 1'b1, "R9 ready before request", 32'(req_ready), 32'd1);
        req_paddr = pa; req_vaddr = va; req_size = sz; req_op = op; req_tagmode = tm;
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        got_n = 0; cyc = 0; done_cyc = -1;
        while (cyc < 4000) begin
            if (wr_strobe) begin
                if (got_n < MAXW) begin
                    got_sel[got_n]  = wr_sel;
                    got_data[got_n] = wr_data;
                end
                got_n++;
            end
            if (done) begin
                done_cyc = cyc;
                break;
            end
            cyc++;
            @(negedge clk);
        end
        check(got_n == exp_n, {tag, " R3 write count"}, 32'(got_n), 32'(exp_n));
        for (int i = 0; i < exp_n && i < got_n && i < MAXW; i++) begin
            check(got_sel[i] == exp_sel[i], {tag, " R1 select"}, 32'(got_sel[i]), 32'(exp_sel[i]));
            check(got_data[i] == exp_data[i], {tag, " data"}, got_data[i], exp_data[i]);
        end
        check(done_cyc == exp_n, {tag, " R9 done timing"}, 32'(done_cyc), 32'(exp_n));
        @(negedge clk);
        check(req_ready === 1'b1 && done === 1'b0, "R9 idle after done", 32'(req_ready), 32'd1);
    endtask

    initial begin
        repeat (200000 - 10) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=<%0d", cycles, 200000);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        logic [31:0] rs;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check(req_ready === 1'b1, "R9 reset ready", 32'(req_ready), 32'd1);
        check(wr_strobe === 1'b0 && done === 1'b0, "R9 reset quiet", 32'(wr_strobe), 32'd0);

        // Directed corners
        run_req(32'h1000_0040, 32'h0003_E040, 32'd0,   3'd1, 1'b0, "R8 zero size");
        run_req(32'h1000_0045, 32'h0003_E045, 32'd0,   3'd3, 1'b1, "R8 zero size tag");
        run_req(32'h1000_001C, 32'h7002_601C, 32'd8,   3'd1, 1'b0, "R2 straddle packed");
        run_req(32'h2000_0000, 32'h0003_E000, 32'd32,  3'd4, 1'b0, "R4 one line ic");
        run_req(32'h2000_0000, 32'h0001_2000, 32'd33,  3'd2, 1'b0, "R5 two lines flush");
        run_req(32'h3000_0010, 32'h4000_0030, 32'd100, 3'd3, 1'b1, "R6 tag partial");
        run_req(32'h5000_2000, 32'h6002_4000, 32'd8192, 3'd3, 1'b1, "R7 tag full page");
        run_req(32'h5000_4000, 32'h6003_C000, 32'd8192, 3'd2, 1'b0, "R10 packed full page");
        run_req(32'h5000_0007, 32'h6000_2007, 32'd8191, 3'd1, 1'b1, "R2 just under page");

        // Random mix
        void'($urandom(32'd2024));
        for (int k = 0; k < 150; k++) begin
            rs = $urandom % 10;
            run_req($urandom, $urandom,
                    (rs == 0) ? 32'(PAGE) : ($urandom % 400),
                    3'(1 + ($urandom % 4)), 1'($urandom % 2), "R1/R6 random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule